// File: doc/BRIEF.md
# SPI FPGA Configuration Sequencer

This block loads a configuration image into the SRAM of a target FPGA over a serial link in which it is the SPI master. A single start pulse runs the whole sequence. First it pulls the target's active-low configuration reset and its chip select low together. It then releases the reset while chip select stays low and confirms that the target's done line reads low. Next it holds chip select low through a long housekeeping wait and then raises it.

The image then streams in as bytes over a valid/ready handshake, and each byte goes out in SPI mode 0, most significant bit first. After the byte marked last, the done line must read high. If it does, seven zero bytes (56 clocks) follow to activate the loaded design.

The outcome is a one-cycle success pulse or a one-cycle error pulse with a code. A start that asks for partial reconfiguration is refused and touches no pin. All waits are counted in system clocks and derived from the clock-frequency parameter. A serial-clock divider that falls outside 1 MHz to 25 MHz stops elaboration.

Top module: `cfg_spi_loader`

## Requirements
- R1: After reset: `creset_n_o`=1, `cs_n_o`=1, `sck_o`=0, `img_ready_o`=0, `busy_o`=0, `done_o`=0, `err_o`=0.
- R2: A start with `partial_i`=1 gives one `err_o` pulse with `err_code_o`=1 on the next cycle and never lowers `creset_n_o` or `cs_n_o`.
- R3: A start lowers `creset_n_o` and `cs_n_o` on the same cycle. `creset_n_o` stays low for exactly ceil(CLK_HZ·RST_NS/1e9) cycles (RST_NS > 200) and rises while `cs_n_o` is still low.
- R4: If `cdone_i` is high in the cycle after reset release, `err_o` pulses with `err_code_o`=2, `cs_n_o` rises, and no image byte is accepted or shifted.
- R5: Otherwise `cs_n_o` stays low through ceil(CLK_HZ·HK_US/1e6) housekeeping cycles. The first chip-select low period lasts RST_CYC+1+HK_CYC cycles, and then `cs_n_o` rises before any serial clock.
- R6: Bytes leave MSB first in mode 0. `mosi_o` is stable while `sck_o` is high, the target samples on the rising edge, and `sck_o` idles low and is low whenever `cs_n_o` is high.
- R7: Each `sck_o` half period is HALF_DIV system cycles. A setting with CLK_HZ/(2·HALF_DIV) outside 1–25 MHz stops elaboration.
- R8: `img_ready_o` is high only in the streaming phase while the shifter is idle and the last byte has not yet been taken. Bytes arrive in order whatever gaps the source leaves.
- R9: If `cdone_i` is low when the last byte has been shifted, `err_o` pulses with `err_code_o`=3 and no padding is sent.
- R10: If `cdone_i` is high then, exactly seven zero bytes are shifted under chip select low, `cs_n_o` rises, and `done_o` pulses.
- R11: `done_o` and `err_o` are each high for exactly one cycle per sequence and never together. Error codes: 1 partial refused, 2 reset failure, 3 configuration incomplete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse (sampled in idle) |
| partial_i | input | 1 | Partial reconfiguration requested with start |
| img_data_i | input | 8 | Image byte |
| img_valid_i | input | 1 | Image byte valid |
| img_last_i | input | 1 | Marks final image byte |
| img_ready_o | output | 1 | Image byte accepted this cycle when valid |
| cdone_i | input | 1 | Target done line |
| creset_n_o | output | 1 | Target configuration reset, active low |
| cs_n_o | output | 1 | Target chip select, active low |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data to target |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle success pulse |
| err_o | output | 1 | One-cycle error pulse |
| err_code_o | output | 2 | Code of the latest error |

## Verification
The main sequence is driven with five input patterns. The first is a partial-reconfiguration start. The second holds done high at reset release while the source offers data the whole time. The third sends a back-to-back image with done rising as the last byte arrives. The fourth sends a throttled image with gaps between bytes. The fifth sends an image after which done never rises.

Each pattern isolates one exit from the sequence, and the back-to-back and throttled runs together separate handshake timing from byte order. A bench-side target model captures bits on each rising serial clock, and its byte queue is compared with the expected image-plus-padding. Per-clock monitors measure the reset width, the chip-select low periods, the clock half periods and data stability.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RESET,
    ST_CHECK_LOW,
    ST_HOUSEKEEP,
    ST_STREAM,
    ST_CHECK_DONE,
    ST_PAD,
    ST_OK,
    ST_ERR
  } seq_state_t;

  typedef enum logic [1:0] {
    ERR_NONE       = 2'd0,
    ERR_PARTIAL    = 2'd1,
    ERR_RESET      = 2'd2,
    ERR_INCOMPLETE = 2'd3
  } err_code_t;

  // ceil(clk_hz * amount / per_sec), amount given in units of 1/per_sec seconds
  function automatic int unsigned cycles_for(longint unsigned clk_hz,
                                             longint unsigned amount,
                                             longint unsigned per_sec);
    longint unsigned q;
    q = (clk_hz * amount + per_sec - 64'd1) / per_sec;
    return 32'(q);
  endfunction

endpackage

// File: rtl/cfg_wait_timer.sv
module cfg_wait_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/cfg_byte_shifter.sv
module cfg_byte_shifter #(
  parameter int unsigned HALF_DIV = 2,
  parameter int unsigned DW       = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [DW-1:0] din,
  output logic          busy,
  output logic          sck,
  output logic          mosi
);
  localparam int unsigned DIVW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int unsigned BITW = $clog2(DW);
  localparam logic [DIVW-1:0] DIV_LAST = DIVW'(HALF_DIV - 1);
  localparam logic [BITW-1:0] BIT_LAST = BITW'(DW - 1);

  logic [DW-1:0]   shreg_q;
  logic [DIVW-1:0] div_q;
  logic [BITW-1:0] bit_q;
  logic            active_q;
  logic            sck_q;
  logic            mosi_q;
  logic            tick;

  assign tick = (div_q == DIV_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg_q  <= '0;
      div_q    <= '0;
      bit_q    <= '0;
      active_q <= 1'b0;
      sck_q    <= 1'b0;
      mosi_q   <= 1'b0;
    end else if (load) begin
      shreg_q  <= din;
      mosi_q   <= din[DW-1];
      div_q    <= '0;
      bit_q    <= '0;
      sck_q    <= 1'b0;
      active_q <= 1'b1;
    end else if (active_q) begin
      if (tick) begin
        div_q <= '0;
        if (!sck_q) begin
          sck_q <= 1'b1;                 // rising edge: target samples
        end else begin
          sck_q <= 1'b0;                 // falling edge: data advances
          if (bit_q == BIT_LAST) begin
            active_q <= 1'b0;
            mosi_q   <= 1'b0;
          end else begin
            bit_q   <= bit_q + 1'b1;
            mosi_q  <= shreg_q[DW-2];
            shreg_q <= shreg_q << 1;
          end
        end
      end else begin
        div_q <= div_q + 1'b1;
      end
    end
  end

  assign busy = active_q;
  assign sck  = sck_q;
  assign mosi = mosi_q;
endmodule

// File: rtl/cfg_spi_loader.sv
module cfg_spi_loader
  import cfg_seq_pkg::*;
#(
  parameter longint unsigned CLK_HZ    = 100_000_000,
  parameter int unsigned     HALF_DIV  = 2,
  parameter int unsigned     RST_NS    = 1000,
  parameter int unsigned     HK_US     = 1200,
  parameter int unsigned     PAD_BYTES = 7
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start_i,
  input  logic       partial_i,
  input  logic [7:0] img_data_i,
  input  logic       img_valid_i,
  input  logic       img_last_i,
  output logic       img_ready_o,
  input  logic       cdone_i,
  output logic       creset_n_o,
  output logic       cs_n_o,
  output logic       sck_o,
  output logic       mosi_o,
  output logic       busy_o,
  output logic       done_o,
  output logic       err_o,
  output logic [1:0] err_code_o
);
  localparam int unsigned RST_CYC = cycles_for(CLK_HZ, 64'(RST_NS), 64'd1_000_000_000);
  localparam int unsigned HK_CYC  = cycles_for(CLK_HZ, 64'(HK_US), 64'd1_000_000);
  localparam int unsigned MAX_CYC = (RST_CYC > HK_CYC) ? RST_CYC : HK_CYC;
  localparam int unsigned TW      = $clog2(MAX_CYC + 1);
  localparam int unsigned PW      = $clog2(PAD_BYTES + 1);
  localparam longint unsigned SCK_HZ = CLK_HZ / (64'd2 * 64'(HALF_DIV));
  localparam logic [PW-1:0] PAD_LAST = PW'(PAD_BYTES);

  if (HALF_DIV == 0 || SCK_HZ > 64'd25_000_000 || SCK_HZ < 64'd1_000_000) begin : g_bad_sck
    $error("serial clock divider gives a rate outside 1..25 MHz");
  end
  if (RST_NS <= 200 || PAD_BYTES == 0 || RST_CYC == 0 || HK_CYC == 0) begin : g_bad_timing
    $error("reset pulse, housekeeping or padding setting out of range");
  end

  seq_state_t     state_q;
  err_code_t      code_q;
  logic           creset_n_q, cs_n_q, done_q, err_q, last_seen_q;
  logic [PW-1:0]  pad_cnt_q;

  logic           tmr_load, tmr_expired;
  logic [TW-1:0]  tmr_val;
  logic           tx_load, tx_busy;
  logic [7:0]     tx_data;
  logic           accept;

  assign img_ready_o = (state_q == ST_STREAM) && !tx_busy && !last_seen_q;
  assign accept      = img_ready_o && img_valid_i;

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    if (state_q == ST_IDLE && start_i && !partial_i) begin
      tmr_load = 1'b1;
      tmr_val  = TW'(RST_CYC - 1);
    end else if (state_q == ST_CHECK_LOW && !cdone_i) begin
      tmr_load = 1'b1;
      tmr_val  = TW'(HK_CYC - 1);
    end
  end

  always_comb begin
    tx_load = 1'b0;
    tx_data = '0;
    if (accept) begin
      tx_load = 1'b1;
      tx_data = img_data_i;
    end else if (state_q == ST_PAD && !tx_busy && pad_cnt_q != PAD_LAST) begin
      tx_load = 1'b1;
    end
  end

  cfg_wait_timer #(.W(TW)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  cfg_byte_shifter #(.HALF_DIV(HALF_DIV), .DW(8)) u_shift (
    .clk  (clk),
    .rst  (rst),
    .load (tx_load),
    .din  (tx_data),
    .busy (tx_busy),
    .sck  (sck_o),
    .mosi (mosi_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      code_q      <= ERR_NONE;
      creset_n_q  <= 1'b1;
      cs_n_q      <= 1'b1;
      done_q      <= 1'b0;
      err_q       <= 1'b0;
      last_seen_q <= 1'b0;
      pad_cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            if (partial_i) begin
              code_q  <= ERR_PARTIAL;
              err_q   <= 1'b1;
              state_q <= ST_ERR;
            end else begin
              code_q     <= ERR_NONE;
              creset_n_q <= 1'b0;
              cs_n_q     <= 1'b0;
              state_q    <= ST_RESET;
            end
          end
        end
        ST_RESET: begin
          if (tmr_expired) begin
            creset_n_q <= 1'b1;
            state_q    <= ST_CHECK_LOW;
          end
        end
        ST_CHECK_LOW: begin
          if (cdone_i) begin
            cs_n_q  <= 1'b1;
            code_q  <= ERR_RESET;
            err_q   <= 1'b1;
            state_q <= ST_ERR;
          end else begin
            state_q <= ST_HOUSEKEEP;
          end
        end
        ST_HOUSEKEEP: begin
          if (tmr_expired) begin
            cs_n_q      <= 1'b1;
            last_seen_q <= 1'b0;
            state_q     <= ST_STREAM;
          end
        end
        ST_STREAM: begin
          if (accept) begin
            cs_n_q <= 1'b0;
            if (img_last_i) last_seen_q <= 1'b1;
          end else if (last_seen_q && !tx_busy) begin
            cs_n_q  <= 1'b1;
            state_q <= ST_CHECK_DONE;
          end
        end
        ST_CHECK_DONE: begin
          if (cdone_i) begin
            cs_n_q    <= 1'b0;
            pad_cnt_q <= '0;
            state_q   <= ST_PAD;
          end else begin
            code_q  <= ERR_INCOMPLETE;
            err_q   <= 1'b1;
            state_q <= ST_ERR;
          end
        end
        ST_PAD: begin
          if (tx_load) begin
            pad_cnt_q <= pad_cnt_q + 1'b1;
          end else if (pad_cnt_q == PAD_LAST && !tx_busy) begin
            cs_n_q  <= 1'b1;
            done_q  <= 1'b1;
            state_q <= ST_OK;
          end
        end
        ST_OK: begin
          done_q  <= 1'b0;
          state_q <= ST_IDLE;
        end
        ST_ERR: begin
          err_q   <= 1'b0;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign creset_n_o = creset_n_q;
  assign cs_n_o     = cs_n_q;
  assign done_o     = done_q;
  assign err_o      = err_q;
  assign err_code_o = code_q;
  assign busy_o     = (state_q != ST_IDLE) && (state_q != ST_OK) && (state_q != ST_ERR);
endmodule

// File: rtl/cfg_spi_loader_chk.sv
module cfg_spi_loader_chk
  import cfg_seq_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input seq_state_t state_q,
  input logic       start_i,
  input logic       partial_i,
  input logic       cdone_i,
  input logic       img_ready_o,
  input logic       creset_n_o,
  input logic       cs_n_o,
  input logic       sck_o,
  input logic       mosi_o,
  input logic       busy_o,
  input logic       done_o,
  input logic       err_o,
  input logic [1:0] err_code_o
);
  p_reset_under_cs_r3: assert property (@(posedge clk) disable iff (rst)
    !creset_n_o |-> !cs_n_o);

  p_partial_refused_r2: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && start_i && partial_i) |=>
      (err_o && err_code_o == 2'd1 && creset_n_o && cs_n_o));

  p_reset_fail_r4: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_CHECK_LOW && cdone_i) |=>
      (err_o && err_code_o == 2'd2 && cs_n_o));

  p_sck_idle_r6: assert property (@(posedge clk) disable iff (rst)
    cs_n_o |-> !sck_o);

  p_mosi_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (sck_o && $past(sck_o)) |-> $stable(mosi_o));

  p_ready_gate_r8: assert property (@(posedge clk) disable iff (rst)
    img_ready_o |-> (busy_o && creset_n_o && !sck_o));

  p_incomplete_r9: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_CHECK_DONE && !cdone_i) |=> (err_o && err_code_o == 2'd3));

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  p_err_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    err_o |=> !err_o);

  p_exclusive_r11: assert property (@(posedge clk) disable iff (rst)
    !(done_o && err_o));
endmodule

bind cfg_spi_loader cfg_spi_loader_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .state_q     (state_q),
  .start_i     (start_i),
  .partial_i   (partial_i),
  .cdone_i     (cdone_i),
  .img_ready_o (img_ready_o),
  .creset_n_o  (creset_n_o),
  .cs_n_o      (cs_n_o),
  .sck_o       (sck_o),
  .mosi_o      (mosi_o),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .err_o       (err_o),
  .err_code_o  (err_code_o)
);

// File: tb/cfg_spi_loader_test.sv
`timescale 1ns/1ps
module cfg_spi_loader_test;
  localparam int CLK_PERIOD = 100;          // 10 MHz system clock
  localparam longint unsigned CLK_HZ = 10_000_000;
  localparam int HALF   = 2;                // 2.5 MHz serial clock
  localparam int RST_NS = 1000;
  localparam int HK_US  = 100;
  localparam int PADN   = 7;
  localparam int RST_CYC = 10;              // ceil(10e6*1000e-9)
  localparam int HK_CYC  = 1000;            // ceil(10e6*100e-6)

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0, partial = 1'b0;
  logic [7:0] data = '0;
  logic valid = 1'b0, last = 1'b0;
  logic cdone = 1'b0;
  logic ready, creset_n, cs_n, sck, mosi, busy, done, err;
  logic [1:0] code;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_spi_loader #(.CLK_HZ(CLK_HZ), .HALF_DIV(HALF), .RST_NS(RST_NS),
                   .HK_US(HK_US), .PAD_BYTES(PADN)) uut (
    .clk(clk), .rst(rst), .start_i(start), .partial_i(partial),
    .img_data_i(data), .img_valid_i(valid), .img_last_i(last),
    .img_ready_o(ready), .cdone_i(cdone), .creset_n_o(creset_n),
    .cs_n_o(cs_n), .sck_o(sck), .mosi_o(mosi), .busy_o(busy),
    .done_o(done), .err_o(err), .err_code_o(code));

  int tests = 0, fails = 0;
  int cycles = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // ---- monitors (reference model state) ----
  int rlow_cur = 0, rlow_last = 0, creset_falls = 0;
  int csl = 0;
  int cs_runs[$];
  int hi = 0;
  int sck_bad = 0, mosi_bad = 0, ready_bad = 0, cs_bad = 0, pulse_bad = 0;
  int done_cnt = 0, err_cnt = 0, last_code = 0;
  logic p_sck = 0, p_mosi = 0, p_done = 0, p_err = 0;
  logic [7:0] rx_q[$];
  logic [7:0] sh = '0;
  int nb = 0;
  bit auto_done = 0;
  int img_len = 0;

  always @(negedge clk) begin
    cycles++;
    if (!rst) begin
      if (!creset_n) rlow_cur++;
      else if (rlow_cur > 0) begin rlow_last = rlow_cur; creset_falls++; rlow_cur = 0; end
      if (!creset_n && cs_n) cs_bad++;
      if (!cs_n) csl++;
      else if (csl > 0) begin cs_runs.push_back(csl); csl = 0; end
      if (sck) hi++;
      else if (hi > 0) begin if (hi != HALF) sck_bad++; hi = 0; end
      if (sck && cs_n) sck_bad++;
      if (sck && p_sck && mosi != p_mosi) mosi_bad++;
      if (ready && (!busy || !creset_n)) ready_bad++;
      if (done) begin done_cnt++; if (p_done) pulse_bad++; end
      if (err) begin err_cnt++; last_code = int'(code); if (p_err) pulse_bad++; end
      if (done && err) pulse_bad++;
      p_sck = sck; p_mosi = mosi; p_done = done; p_err = err;
    end
  end

  // target model: samples on rising serial clock
  always @(posedge sck) begin
    if (!cs_n) begin
      sh = {sh[6:0], mosi};
      nb++;
      if (nb == 8) begin
        rx_q.push_back(sh);
        nb = 0;
        if (auto_done && rx_q.size() == img_len) cdone = 1'b1;
      end
    end
  end
  always @(posedge cs_n) nb = 0;

  task automatic clear_run();
    cs_runs.delete(); rx_q.delete();
    done_cnt = 0; err_cnt = 0; last_code = 0;
    creset_falls = 0; rlow_last = 0;
  endtask

  task automatic kick(input bit part);
    @(negedge clk); start = 1'b1; partial = part;
    @(negedge clk); start = 1'b0; partial = 1'b0;
  endtask

  task automatic send(input logic [7:0] img[$], input int gap);
    for (int i = 0; i < img.size(); i++) begin
      int n;
      data = img[i]; valid = 1'b1; last = (i == img.size() - 1);
      n = 0;
      while (!ready && n < 5000) begin @(negedge clk); n++; end
      @(negedge clk);
      valid = 1'b0; last = 1'b0;
      repeat (gap) @(negedge clk);
    end
  endtask

  task automatic wait_end();
    int n;
    n = 0;
    while (done_cnt == 0 && err_cnt == 0 && n < 20000) begin @(negedge clk); n++; end
    repeat (5) @(negedge clk);
  endtask

  task automatic cmp_rx(input logic [7:0] exp_q[$], input string req);
    chk(rx_q.size() == exp_q.size(), req, "byte count", rx_q.size(), exp_q.size());
    if (rx_q.size() == exp_q.size())
      for (int i = 0; i < exp_q.size(); i++)
        chk(rx_q[i] == exp_q[i], req, $sformatf("byte %0d", i), rx_q[i], exp_q[i]);
  endtask

  initial begin : watchdog
    while (cycles < 150000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog: actual %0d expected <150000 cycles", cycles);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : main
    logic [7:0] img_a[$];
    logic [7:0] img_b[$];
    logic [7:0] exp_q[$];
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(creset_n == 1 && cs_n == 1, "R1", "creset_n/cs_n", {creset_n, cs_n}, 3);
    chk(sck == 0 && ready == 0 && busy == 0, "R1", "sck/ready/busy", {sck, ready, busy}, 0);
    chk(done == 0 && err == 0, "R1", "done/err", {done, err}, 0);

    // R2 partial request refused
    clear_run();
    kick(1'b1);
    repeat (5) @(negedge clk);
    chk(err_cnt == 1 && last_code == 1, "R2", "partial error code", last_code, 1);
    chk(creset_falls == 0 && cs_runs.size() == 0, "R2", "pins untouched",
        creset_falls + cs_runs.size(), 0);

    // R4 done stuck high after reset release; source offers data throughout
    clear_run();
    cdone = 1'b1; auto_done = 0;
    data = 8'h55; valid = 1'b1;
    kick(1'b0);
    wait_end();
    valid = 1'b0;
    chk(last_code == 2 && err_cnt == 1, "R4", "reset-failure code", last_code, 2);
    chk(rlow_last == RST_CYC, "R3", "reset low cycles", rlow_last, RST_CYC);
    chk(cs_runs.size() == 1 && cs_n == 1, "R4", "chip select released", cs_runs.size(), 1);
    if (cs_runs.size() > 0)
      chk(cs_runs[0] == RST_CYC + 1, "R4", "cs low length", cs_runs[0], RST_CYC + 1);
    chk(rx_q.size() == 0, "R4", "no bytes shifted", rx_q.size(), 0);

    // R10 normal load, back-to-back source
    clear_run();
    cdone = 1'b0;
    img_a = '{8'hA5, 8'h3C, 8'hFF, 8'h00, 8'h81};
    img_len = img_a.size(); auto_done = 1;
    kick(1'b0);
    send(img_a, 0);
    wait_end();
    chk(rlow_last == RST_CYC, "R3", "reset low cycles", rlow_last, RST_CYC);
    if (cs_runs.size() > 0)
      chk(cs_runs[0] == RST_CYC + 1 + HK_CYC, "R5", "housekeeping cs low",
          cs_runs[0], RST_CYC + 1 + HK_CYC);
    chk(cs_runs.size() == 3, "R10", "chip-select frames", cs_runs.size(), 3);
    exp_q = img_a;
    for (int i = 0; i < PADN; i++) exp_q.push_back(8'h00);
    cmp_rx(exp_q, "R6");
    chk(done_cnt == 1 && err_cnt == 0, "R10", "done pulse count", done_cnt, 1);

    // R8 throttled source, different bytes
    clear_run();
    cdone = 1'b0;
    img_b = '{8'h01, 8'h80, 8'h7E, 8'hC3};
    img_len = img_b.size(); auto_done = 1;
    kick(1'b0);
    send(img_b, 23);
    wait_end();
    exp_q = img_b;
    for (int i = 0; i < PADN; i++) exp_q.push_back(8'h00);
    cmp_rx(exp_q, "R8");
    chk(done_cnt == 1, "R10", "done pulse count", done_cnt, 1);

    // R9 done never rises
    clear_run();
    cdone = 1'b0; auto_done = 0;
    img_len = img_a.size();
    kick(1'b0);
    send(img_a, 3);
    wait_end();
    chk(err_cnt == 1 && last_code == 3, "R9", "incomplete code", last_code, 3);
    cmp_rx(img_a, "R9");
    chk(done_cnt == 0, "R9", "no done pulse", done_cnt, 0);

    // invariants over all runs
    chk(sck_bad == 0, "R7", "sck half period / idle", sck_bad, 0);
    chk(mosi_bad == 0, "R6", "mosi change while sck high", mosi_bad, 0);
    chk(cs_bad == 0, "R3", "reset outside chip select", cs_bad, 0);
    chk(ready_bad == 0, "R8", "ready outside streaming", ready_bad, 0);
    chk(pulse_bad == 0, "R11", "pulse width / overlap", pulse_bad, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule